// File: doc/BRIEF.md
# Sample Capture Buffer

This block records a stream of converter samples into on-chip memory while a write enable is held high, then plays them back one sample per read strobe. The number of samples it holds is chosen at run time from two sizes through a small configuration port. A full flag rises once that many samples have been stored since the last pointer reset.

The capture pointers are cleared by a dedicated pointer-reset input. A pulse on that input counts only if it is long enough. A newly chosen depth waits until the next qualified pointer reset before it takes effect. After that reset releases, writes are held off for a short settling window, and a sticky drop flag shows that samples offered during the window were thrown away.

A stop-when-full option keeps the first samples captured. With that option off, the buffer keeps overwriting its oldest entries and plays back from the oldest sample still held. Everything runs on one write clock. The read strobe is sampled on that same clock.

Top module: `sample_capture_buf`

## Requirements
- R1: The capture depth is 2^AW_HI samples when the deep configuration bit is 1 and 2^AW_LO samples when it is 0. After module reset the depth is the small one.
- R2: `full_o` goes high in the cycle after the depth-th accepted write following a qualified pointer reset, and stays low before that.
- R3: A qualified pointer reset clears the stored count, the write and read positions, `full_o`, `empty_o` and `drop_o`. A qualified reset is `ptr_rst_i` held high for at least MIN_RST clocks and then released.
- R4: A `ptr_rst_i` pulse shorter than MIN_RST clocks has no effect: `full_o` and the read position are kept, and the configured depth stays pending.
- R5: After a qualified reset, writes in the release cycle and in the next SETTLE cycles are not stored. Each write offered in those SETTLE cycles sets `drop_o`, which stays set until the next qualified reset.
- R6: Writing a new depth with no qualified reset after it leaves the old depth in force.
- R7: With stop-when-full set (`cfg_autostop_i` = 1 at a config write), writes after `full_o` is high are discarded, and the first depth samples read back unchanged.
- R8: With stop-when-full clear, writing continues past full. The write position wraps modulo the depth and `full_o` stays high. Playback starts at the oldest sample still held.
- R9: Each `rd_stb_i` returns the next stored sample on `rd_data_o` in the following cycle, in capture order, starting from the first stored sample.
- R10: A strobe once every stored sample has been read leaves `rd_data_o` at the last valid sample and sets `empty_o`.
- R11: After module reset, `full_o`, `empty_o` and `drop_o` are low and stop-when-full is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, also samples the read strobe |
| rst | input | 1 | Synchronous active-high module reset |
| smp_i | input | SMP_W | Sample to store |
| wr_en_i | input | 1 | Store `smp_i` this cycle |
| ptr_rst_i | input | 1 | Pointer reset, qualified by minimum width |
| cfg_we_i | input | 1 | Load the configuration bits |
| cfg_deep_i | input | 1 | 1 selects the large depth (pending until pointer reset) |
| cfg_autostop_i | input | 1 | 1 stops writing when full, 0 wraps |
| rd_stb_i | input | 1 | Advance playback by one sample |
| rd_data_o | output | SMP_W | Registered playback sample |
| full_o | output | 1 | Selected number of samples stored |
| empty_o | output | 1 | A strobe found nothing left to read |
| drop_o | output | 1 | A write was discarded in the settling window |

## Verification
The bench builds the block with AW_LO = 4 and AW_HI = 6, giving 16 and 64 sample depths, and keeps MIN_RST = 3 and SETTLE = 2. The small depths let every full boundary, a wrap and an overwrite be reached within a few hundred cycles. They also let random rounds switch depth and stop mode many times and read each capture back to the end. With the default reset width and settling window, the one-short pulse and the exact release and window cycles can be hit directly.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic deep;
    logic autostop;
  } cap_cfg_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int MIN_RST = 3,
  parameter int SETTLE  = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ptr_rst_i,
  input  logic     cfg_we_i,
  input  cap_cfg_t cfg_i,
  input  logic     wr_en_i,
  output logic     clr_o,
  output logic     block_o,
  output logic     deep_o,
  output logic     autostop_o,
  output logic     drop_o
);
  localparam int RCW = $clog2(MIN_RST + 1);
  localparam int GW  = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

  logic [RCW-1:0] run_q;
  logic           rst_q;
  logic [GW-1:0]  guard_q;
  logic           pend_deep_q;

  // Width counter for the pointer reset pulse, saturating at the minimum.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= ptr_rst_i;
      if (!ptr_rst_i)                 run_q <= '0;
      else if (run_q != RCW'(MIN_RST)) run_q <= run_q + 1'b1;
    end
  end

  assign clr_o = rst_q && !ptr_rst_i && (run_q == RCW'(MIN_RST));

  // Configuration: depth stays pending until a qualified clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_deep_q <= 1'b0;
      deep_o      <= 1'b0;
      autostop_o  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        pend_deep_q <= cfg_i.deep;
        autostop_o  <= cfg_i.autostop;
      end
      if (clr_o) deep_o <= pend_deep_q;
    end
  end

  // Settling window and drop record.
  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q <= '0;
      drop_o  <= 1'b0;
    end else if (clr_o) begin
      guard_q <= GW'(SETTLE);
      drop_o  <= 1'b0;
    end else begin
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      if (wr_en_i && guard_q != '0) drop_o <= 1'b1;
    end
  end

  assign block_o = ptr_rst_i || rst_q || (guard_q != '0);

  p_pending_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_o |=> $stable(deep_o));
  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && guard_q != '0) |=> drop_o);
endmodule

// File: rtl/cap_wr.sv
module cap_wr #(
  parameter int AW_LO = 10,
  parameter int AW_HI = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             block_i,
  input  logic             wr_en_i,
  input  logic             deep_i,
  input  logic             autostop_i,
  output logic             we_o,
  output logic [AW_HI-1:0] waddr_o,
  output logic [AW_HI:0]   fill_o,
  output logic [AW_HI:0]   depth_o,
  output logic             full_o
);
  localparam int DW = AW_HI + 1;

  logic accept;

  assign depth_o = deep_i ? (DW'(1) << AW_HI) : (DW'(1) << AW_LO);
  assign accept  = wr_en_i && !block_i && !clr_i && !(autostop_i && full_o);
  assign we_o    = accept;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      waddr_o <= '0;
      fill_o  <= '0;
      full_o  <= 1'b0;
    end else if (accept) begin
      if (DW'(waddr_o) == depth_o - DW'(1)) waddr_o <= '0;
      else                                  waddr_o <= waddr_o + 1'b1;
      if (fill_o != depth_o)                fill_o  <= fill_o + 1'b1;
      if (fill_o == depth_o - DW'(1))       full_o  <= 1'b1;
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (fill_o == '0 && !full_o && waddr_o == '0));
  p_full_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && !clr_i) |=> full_o);
  p_autostop_r7: assert property (@(posedge clk) disable iff (rst)
    (full_o && autostop_i && !clr_i) |=> $stable(waddr_o));
  p_block_r5: assert property (@(posedge clk) disable iff (rst)
    (block_i && !clr_i) |=> $stable(fill_o));
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_o <= depth_o);
endmodule

// File: rtl/cap_rd.sv
module cap_rd #(
  parameter int AW_HI = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [AW_HI:0]   fill_i,
  input  logic [AW_HI:0]   depth_i,
  input  logic             full_i,
  input  logic [AW_HI-1:0] waddr_i,
  output logic             re_o,
  output logic [AW_HI-1:0] raddr_o,
  output logic             empty_o
);
  localparam int DW = AW_HI + 1;

  logic [DW-1:0] idx_q;
  logic [DW-1:0] base;
  logic [DW-1:0] sum;
  logic          avail;

  // Oldest sample sits at the write position once the buffer has filled.
  assign base    = full_i ? DW'(waddr_i) : '0;
  assign sum     = base + idx_q;
  assign raddr_o = (sum >= depth_i) ? AW_HI'(sum - depth_i) : AW_HI'(sum);
  assign avail   = idx_q < fill_i;
  assign re_o    = stb_i && avail && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      idx_q   <= '0;
      empty_o <= 1'b0;
    end else if (stb_i) begin
      if (avail) begin
        idx_q   <= idx_q + 1'b1;
        empty_o <= 1'b0;
      end else begin
        empty_o <= 1'b1;
      end
    end
  end

  p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
    idx_q <= fill_i);
  p_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !avail && !clr_i) |=> (empty_o && $stable(idx_q)));
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int N = 1 << AW;

  logic [W-1:0] ram [N];

  always_ff @(posedge clk) begin
    if (we_i) ram[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= ram[raddr_i];
  end
endmodule

// File: rtl/sample_capture_buf.sv
module sample_capture_buf
  import cap_pkg::*;
#(
  parameter int SMP_W   = 8,
  parameter int AW_LO   = 10,
  parameter int AW_HI   = 12,
  parameter int MIN_RST = 3,
  parameter int SETTLE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             wr_en_i,
  input  logic             ptr_rst_i,
  input  logic             cfg_we_i,
  input  logic             cfg_deep_i,
  input  logic             cfg_autostop_i,
  input  logic             rd_stb_i,
  output logic [SMP_W-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  cap_cfg_t         cfg;
  logic             clr, block, deep, autostop;
  logic             we, re;
  logic [AW_HI-1:0] waddr, raddr;
  logic [AW_HI:0]   fill, depth;

  assign cfg.deep     = cfg_deep_i;
  assign cfg.autostop = cfg_autostop_i;

  cap_ctrl #(.MIN_RST(MIN_RST), .SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst(rst), .ptr_rst_i(ptr_rst_i), .cfg_we_i(cfg_we_i),
    .cfg_i(cfg), .wr_en_i(wr_en_i), .clr_o(clr), .block_o(block),
    .deep_o(deep), .autostop_o(autostop), .drop_o(drop_o)
  );

  cap_wr #(.AW_LO(AW_LO), .AW_HI(AW_HI)) u_wr (
    .clk(clk), .rst(rst), .clr_i(clr), .block_i(block), .wr_en_i(wr_en_i),
    .deep_i(deep), .autostop_i(autostop), .we_o(we), .waddr_o(waddr),
    .fill_o(fill), .depth_o(depth), .full_o(full_o)
  );

  cap_rd #(.AW_HI(AW_HI)) u_rd (
    .clk(clk), .rst(rst), .clr_i(clr), .stb_i(rd_stb_i), .fill_i(fill),
    .depth_i(depth), .full_i(full_o), .waddr_i(waddr), .re_o(re),
    .raddr_o(raddr), .empty_o(empty_o)
  );

  cap_mem #(.W(SMP_W), .AW(AW_HI)) u_mem (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(smp_i),
    .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  p_out_flags_r11: assert property (@(posedge clk)
    rst |=> (!full_o && !empty_o && !drop_o));
endmodule

// File: tb/sim_sample_capture_buf.sv
`timescale 1ns/1ps
module sim_sample_capture_buf;
  localparam int LO = 4, HI = 6, MINR = 3, SET = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] smp_i = '0;
  logic wr_en_i = 0, ptr_rst_i = 0, cfg_we_i = 0, cfg_deep_i = 0;
  logic cfg_autostop_i = 0, rd_stb_i = 0;
  logic [7:0] rd_data_o;
  logic full_o, empty_o, drop_o;

  int checks = 0, fails = 0;
  logic [7:0] wq [256];
  int nw = 0, nrd = 0, dep = 16, pend_dep = 16;
  bit as_mode = 0;

  always #4 clk = ~clk;

  sample_capture_buf #(.SMP_W(8), .AW_LO(LO), .AW_HI(HI), .MIN_RST(MINR),
                       .SETTLE(SET)) u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stored();
    return (nw < dep) ? nw : dep;
  endfunction

  function automatic logic [7:0] exp_at(int k);
    if (!as_mode && nw > dep) return wq[nw - dep + k];
    return wq[k];
  endfunction

  task automatic cfg(bit d, bit a);
    cfg_deep_i = d; cfg_autostop_i = a; cfg_we_i = 1;
    @(negedge clk);
    cfg_we_i = 0;
    pend_dep = d ? 64 : 16;
    as_mode = a;
  endtask

  task automatic preset(int n);
    ptr_rst_i = 1;
    repeat (n) @(negedge clk);
    ptr_rst_i = 0;
    repeat (1 + SET) @(negedge clk);
    if (n >= MINR) begin
      nw = 0; nrd = 0; dep = pend_dep;
    end
  endtask

  task automatic wr_n(int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      smp_i = v; wr_en_i = 1;
      @(negedge clk);
      if (!(as_mode && nw >= dep)) begin
        wq[nw] = v; nw++;
      end
    end
    wr_en_i = 0;
  endtask

  task automatic rd_n(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] prev, e;
      bit past;
      prev = rd_data_o;
      past = (nrd >= stored());
      e = past ? prev : exp_at(nrd);
      rd_stb_i = 1;
      @(negedge clk);
      rd_stb_i = 0;
      chk(rd_data_o === e, req, int'(rd_data_o), int'(e));
      chk(empty_o === past, {req, " empty"}, int'(empty_o), int'(past));
      if (!past) nrd++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(full_o === 0, "R11", int'(full_o), 0);
    chk(empty_o === 0, "R11", int'(empty_o), 0);
    chk(drop_o === 0, "R11", int'(drop_o), 0);

    // R1/R2 small default depth
    preset(3);
    wr_n(15);
    chk(full_o === 0, "R2", int'(full_o), 0);
    wr_n(1);
    chk(full_o === 1, "R2", int'(full_o), 1);
    rd_n(16, "R9");
    rd_n(2, "R10");

    // R6 depth change pending without pointer reset
    preset(3);
    cfg(1, 0);
    wr_n(15);
    chk(full_o === 0, "R6", int'(full_o), 0);
    wr_n(1);
    chk(full_o === 1, "R6 old depth kept", int'(full_o), 1);

    // R1 large depth after qualified reset
    preset(3);
    wr_n(63);
    chk(full_o === 0, "R1", int'(full_o), 0);
    wr_n(1);
    chk(full_o === 1, "R1", int'(full_o), 1);
    rd_n(5, "R9");

    // R4 short pulse ignored
    cfg(0, 0);
    preset(MINR - 1);
    chk(full_o === 1, "R4", int'(full_o), 1);
    rd_n(3, "R4 read position");

    // R7 stop when full
    cfg(0, 1);
    preset(4);
    wr_n(21);
    chk(full_o === 1, "R7", int'(full_o), 1);
    rd_n(17, "R7");

    // R8 wrap, oldest first
    cfg(0, 0);
    preset(3);
    wr_n(23);
    chk(full_o === 1, "R8", int'(full_o), 1);
    rd_n(17, "R8");

    // R5 settling window
    ptr_rst_i = 1;
    repeat (MINR) @(negedge clk);
    ptr_rst_i = 0;
    wr_en_i = 1;
    smp_i = 8'hA1; @(negedge clk);
    smp_i = 8'hB2; @(negedge clk);
    smp_i = 8'hC3; @(negedge clk);
    smp_i = 8'hD4; @(negedge clk);
    wr_en_i = 0;
    nw = 1; nrd = 0; dep = pend_dep; wq[0] = 8'hD4;
    chk(drop_o === 1, "R5", int'(drop_o), 1);
    rd_n(2, "R5 first stored");

    // R3 clear of flags
    preset(3);
    chk(drop_o === 0, "R3", int'(drop_o), 0);
    chk(empty_o === 0, "R3", int'(empty_o), 0);
    chk(full_o === 0, "R3", int'(full_o), 0);

    // Random rounds across depth and mode (R1 R2 R7 R8 R9 R10)
    for (int r = 0; r < 8; r++) begin
      int n;
      cfg(1'($urandom), 1'($urandom));
      preset(MINR + int'($urandom % 3));
      n = 1 + int'($urandom % (dep + 20));
      wr_n(n);
      chk(full_o === (nw >= dep), "R2 random", int'(full_o), int'(nw >= dep));
      rd_n(stored() + 2, "R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule